// File: doc/BRIEF.md
# Boundary-Scan Self-Test Pattern Engine

This block is the test engine behind an 18-cell boundary register that wraps an octal latch. Eight input cells sit between the input pins and the core logic. Eight output cells sit between the core and the output pins. Two control cells complete the register. A 2-bit opcode picks one of four self-test operations. The chosen operation steps once per rising edge of the test clock, for as long as the qualifier input reports that the test-access controller is in its idle run state under the run-test instruction.

The same 18 flops act as a sample/toggle register, a 16-bit pattern generator, a 16-bit multiple-input signature register, or an 8-bit signature register and an 8-bit pattern generator side by side. The operation is chosen by the opcode. Stepping happens on the rising clock edge. The shadow latches that drive the output pins and the core inputs are written on the following falling edge. A seed is placed in the register before a run, either in one parallel load or serially through the scan path. The same scan path reads out the result when the run is over.

Top module: `bscan_pattern_engine`

## Requirements
- R1: While reset is asserted, all 18 cells and all shadow latches clear, so `pinOe`, `pinOut`, `coreIn` and `scanOut` are all zero.
- R2: `seedLoad` has priority over `shiftEn`, and `shiftEn` has priority over a test step. A load writes `seedValue` into all 18 cells. On the next falling edge, the input shadow takes bits 7:0, the output shadow takes bits 15:8 and the enable shadow takes bit 16.
- R3: With `shiftEn` high, the register moves one place toward bit 0 on each rising edge. `scanIn` enters bit 17, and `scanOut` always shows bit 0. Shifting leaves every shadow latch, and therefore the pins, unchanged.
- R4: Opcode 00 (sample/toggle). Bits 7:0 capture `pinIn` and bits 15:8 invert. On the falling edge, `coreIn` shows the captured byte and `pinOut` shows the inverted byte.
- R5: Opcode 01 (pattern, 16-bit). Bits 15:0 shift toward bit 15, and bit 0 receives bit15^bit11^bit2^bit0 (x^16+x^12+x^3+x+1). Both data shadows update, so `pinOut`=bits 15:8 and `coreIn`=bits 7:0. An all-zero state stays zero.
- R6: Opcode 10 (signature, 16-bit). Bits 15:0 take the R5 step XORed with `pinIn` on bits 7:0. `pinOut` and `coreIn` hold their values.
- R7: Opcode 11 (dual 8-bit). Bits 7:0 shift toward bit 7 with feedback bit7^bit3^bit2^bit1 into bit 0, and the result is XORed with `pinIn`. In the same edge, bits 15:8 shift with feedback bit15^bit11^bit10^bit9 into bit 8. `pinOut` takes the new bits 15:8, and `coreIn` holds.
- R8: No test operation changes control cells 17 and 16.
- R9: `pinOe` follows the enable shadow of cell 16 (1 = drive). The enable shadow refreshes on the falling edge after every load or test step.
- R10: With `runTest`, `seedLoad` and `shiftEn` all low, the register and all shadows hold their values, whatever `pinIn` and the opcode do.
- R11: Opcode 01 started from a nonzero 16-bit seed returns to that seed after exactly 65535 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; cells step on the rising edge and shadows update on the falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| runTest | input | 1 | High while the controller is in its idle run state under the run-test instruction |
| opcode | input | 2 | Test operation select: 00 sample/toggle, 01 pattern, 10 signature, 11 dual 8-bit |
| pinIn | input | 8 | Input pin values |
| seedLoad | input | 1 | Parallel load of `seedValue` into the register |
| seedValue | input | 18 | Parallel seed |
| shiftEn | input | 1 | Serial shift of the register |
| scanIn | input | 1 | Serial data into bit 17 |
| pinOut | output | 8 | Output pin values from the output shadow |
| pinOe | output | 1 | Output pin drive enable (0 = high impedance) |
| coreIn | output | 8 | Values presented to the core from the input shadow |
| scanOut | output | 1 | Serial data from bit 0 |

## Verification
Under opcode 11, signature compression on the input half and pattern generation on the output half happen on the same rising edge. Each half has its own feedback, so a wrong tap or a crossed half shows up either in `pinOut` on every cycle or in the signature read back afterward. The bench drives a changing pin sequence while both halves run. It then freezes the register and scans all 18 bits out. Each bit is compared with a model built from the polynomials in R5 to R7. The falling-edge shadow update of one step also lands between two rising edges of a continuous run. For that reason, pins are sampled after every falling edge throughout the full 65535-step pattern cycle.

// File: rtl/bscan_engine_pkg.sv
`timescale 1ns/1ps
package bscan_engine_pkg;

  typedef enum logic [2:0] {
    STEP_NONE,
    STEP_SAMPLE,
    STEP_PRPG,
    STEP_PSA,
    STEP_DUAL
  } stepOp_e;

  typedef struct packed {
    logic    load;
    logic    shift;
    stepOp_e op;
  } ctrlStrobe_t;

  typedef struct packed {
    logic updIn;
    logic updOut;
    logic updOe;
  } updFlags_t;

endpackage

// File: rtl/bscan_engine_ctrl.sv
`timescale 1ns/1ps
module bscan_engine_ctrl
  import bscan_engine_pkg::*;
(
  input  logic        tck,
  input  logic        rstN,
  input  logic        runTest,
  input  logic [1:0]  opcode,
  input  logic        seedLoad,
  input  logic        shiftEn,
  output ctrlStrobe_t strobe,
  output updFlags_t   upd
);

  always_comb begin
    strobe = '{load: 1'b0, shift: 1'b0, op: STEP_NONE};
    if (seedLoad) begin
      strobe.load = 1'b1;
    end else if (shiftEn) begin
      strobe.shift = 1'b1;
    end else if (runTest) begin
      unique case (opcode)
        2'b00: strobe.op = STEP_SAMPLE;
        2'b01: strobe.op = STEP_PRPG;
        2'b10: strobe.op = STEP_PSA;
        default: strobe.op = STEP_DUAL;
      endcase
    end
  end

  updFlags_t updNext;

  always_comb begin
    updNext = '0;
    if (strobe.load) begin
      updNext = '{updIn: 1'b1, updOut: 1'b1, updOe: 1'b1};
    end else begin
      unique case (strobe.op)
        STEP_SAMPLE: updNext = '{updIn: 1'b1, updOut: 1'b1, updOe: 1'b1};
        STEP_PRPG:   updNext = '{updIn: 1'b1, updOut: 1'b1, updOe: 1'b1};
        STEP_PSA:    updNext = '{updIn: 1'b0, updOut: 1'b0, updOe: 1'b1};
        STEP_DUAL:   updNext = '{updIn: 1'b0, updOut: 1'b1, updOe: 1'b1};
        default:     updNext = '0;
      endcase
    end
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) upd <= '0;
    else       upd <= updNext;
  end

  // R6: a signature step never refreshes the data shadows
  p_psa_no_update_r6: assert property (@(posedge tck) disable iff (!rstN)
    (strobe.op == STEP_PSA) |=> (!upd.updIn && !upd.updOut));

  // R2: a load schedules every shadow for the next falling edge
  p_load_updates_r2: assert property (@(posedge tck) disable iff (!rstN)
    strobe.load |=> (upd.updIn && upd.updOut && upd.updOe));

  // R10: an idle cycle schedules no shadow update
  p_idle_no_update_r10: assert property (@(posedge tck) disable iff (!rstN)
    (!seedLoad && !shiftEn && !runTest) |=> (upd == '0));

endmodule

// File: rtl/bscan_engine_datapath.sv
`timescale 1ns/1ps
module bscan_engine_datapath
  import bscan_engine_pkg::*;
#(
  parameter int             DATA_W      = 8,
  parameter logic [2*DATA_W-1:0] WIDE_TAPS   = 16'h8805,
  parameter logic [DATA_W-1:0]   NARROW_TAPS = 8'h8E
) (
  input  logic                  tck,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  updFlags_t             upd,
  input  logic [DATA_W-1:0]     pinIn,
  input  logic [2*DATA_W+1:0]   seedValue,
  input  logic                  scanIn,
  output logic [DATA_W-1:0]     pinOut,
  output logic                  pinOe,
  output logic [DATA_W-1:0]     coreIn,
  output logic                  scanOut
);

  localparam int WIDE  = 2 * DATA_W;
  localparam int CELLS = WIDE + 2;
  localparam int OE_BIT = WIDE;

  logic [CELLS-1:0]  bndReg;
  logic [CELLS-1:0]  regNext;
  logic [DATA_W-1:0] inCells, outCells;
  logic [WIDE-1:0]   dataCells;

  assign dataCells = bndReg[WIDE-1:0];
  assign inCells   = bndReg[DATA_W-1:0];
  assign outCells  = bndReg[WIDE-1:DATA_W];

  // per-cell sample/toggle behaviour
  logic [WIDE-1:0] sampleNext;
  for (genvar i = 0; i < WIDE; i++) begin : g_cell
    if (i < DATA_W) begin : g_in
      assign sampleNext[i] = pinIn[i];
    end else begin : g_out
      assign sampleNext[i] = ~bndReg[i];
    end
  end

  logic            fbWide, fbIn, fbOut;
  logic [WIDE-1:0] prpgNext, psaNext, dualNext;

  assign fbWide   = ^(dataCells & WIDE_TAPS);
  assign fbIn     = ^(inCells & NARROW_TAPS);
  assign fbOut    = ^(outCells & NARROW_TAPS);
  assign prpgNext = {dataCells[WIDE-2:0], fbWide};
  assign psaNext  = prpgNext ^ {{DATA_W{1'b0}}, pinIn};
  assign dualNext = {outCells[DATA_W-2:0], fbOut,
                     ({inCells[DATA_W-2:0], fbIn} ^ pinIn)};

  always_comb begin
    regNext = bndReg;
    if (strobe.load) begin
      regNext = seedValue;
    end else if (strobe.shift) begin
      regNext = {scanIn, bndReg[CELLS-1:1]};
    end else begin
      unique case (strobe.op)
        STEP_SAMPLE: regNext[WIDE-1:0] = sampleNext;
        STEP_PRPG:   regNext[WIDE-1:0] = prpgNext;
        STEP_PSA:    regNext[WIDE-1:0] = psaNext;
        STEP_DUAL:   regNext[WIDE-1:0] = dualNext;
        default:     regNext = bndReg;
      endcase
    end
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) bndReg <= '0;
    else       bndReg <= regNext;
  end

  // shadow latches written on the falling edge
  logic [DATA_W-1:0] inShadow, outShadow;
  logic              oeShadow;

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      inShadow  <= '0;
      outShadow <= '0;
      oeShadow  <= 1'b0;
    end else begin
      if (upd.updIn)  inShadow  <= inCells;
      if (upd.updOut) outShadow <= outCells;
      if (upd.updOe)  oeShadow  <= bndReg[OE_BIT];
    end
  end

  assign pinOut  = outShadow;
  assign pinOe   = oeShadow;
  assign coreIn  = inShadow;
  assign scanOut = bndReg[0];

  // R8: control cells survive every test step
  p_ctrl_cells_hold_r8: assert property (@(posedge tck) disable iff (!rstN)
    (strobe.op != STEP_NONE) |=> (bndReg[CELLS-1:WIDE] == $past(bndReg[CELLS-1:WIDE])));

  // R10: idle keeps the register frozen
  p_freeze_r10: assert property (@(posedge tck) disable iff (!rstN)
    (!strobe.load && !strobe.shift && strobe.op == STEP_NONE) |=> $stable(bndReg));

  // R5: zero state locks the pattern generator
  p_zero_lock_r5: assert property (@(posedge tck) disable iff (!rstN)
    (strobe.op == STEP_PRPG && dataCells == '0) |=> (bndReg[WIDE-1:0] == '0));

  // R4: output cells invert on a sample/toggle step
  p_toggle_r4: assert property (@(posedge tck) disable iff (!rstN)
    (strobe.op == STEP_SAMPLE) |=> (bndReg[WIDE-1:DATA_W] == ~$past(bndReg[WIDE-1:DATA_W])));

  // R3: serial shift moves bit 1 into bit 0
  p_shift_r3: assert property (@(posedge tck) disable iff (!rstN)
    strobe.shift |=> (bndReg[0] == $past(bndReg[1])));

endmodule

// File: rtl/bscan_pattern_engine.sv
`timescale 1ns/1ps
module bscan_pattern_engine
  import bscan_engine_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [2*DATA_W-1:0] WIDE_TAPS   = 16'h8805,
  parameter logic [DATA_W-1:0]   NARROW_TAPS = 8'h8E
) (
  input  logic                tck,
  input  logic                rstN,
  input  logic                runTest,
  input  logic [1:0]          opcode,
  input  logic [DATA_W-1:0]   pinIn,
  input  logic                seedLoad,
  input  logic [2*DATA_W+1:0] seedValue,
  input  logic                shiftEn,
  input  logic                scanIn,
  output logic [DATA_W-1:0]   pinOut,
  output logic                pinOe,
  output logic [DATA_W-1:0]   coreIn,
  output logic                scanOut
);

  ctrlStrobe_t strobe;
  updFlags_t   upd;

  bscan_engine_ctrl ctrl_i (
    .tck      (tck),
    .rstN     (rstN),
    .runTest  (runTest),
    .opcode   (opcode),
    .seedLoad (seedLoad),
    .shiftEn  (shiftEn),
    .strobe   (strobe),
    .upd      (upd)
  );

  bscan_engine_datapath #(
    .DATA_W      (DATA_W),
    .WIDE_TAPS   (WIDE_TAPS),
    .NARROW_TAPS (NARROW_TAPS)
  ) dp_i (
    .tck       (tck),
    .rstN      (rstN),
    .strobe    (strobe),
    .upd       (upd),
    .pinIn     (pinIn),
    .seedValue (seedValue),
    .scanIn    (scanIn),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .coreIn    (coreIn),
    .scanOut   (scanOut)
  );

endmodule

// File: tb/bscan_pattern_engine_tb.sv
`timescale 1ns/1ps
module bscan_pattern_engine_tb_top;

  logic        tck = 1'b0;
  logic        rstN = 1'b0;
  logic        runTest = 1'b0;
  logic [1:0]  opcode = 2'b00;
  logic [7:0]  pinIn = '0;
  logic        seedLoad = 1'b0;
  logic [17:0] seedValue = '0;
  logic        shiftEn = 1'b0;
  logic        scanIn = 1'b0;
  logic [7:0]  pinOut, coreIn;
  logic        pinOe, scanOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference state
  logic [17:0] mReg = '0;
  logic [7:0]  mIn = '0, mOut = '0;
  logic        mOe = 1'b0;

  always #10 tck = ~tck;

  bscan_pattern_engine dut_i (
    .tck(tck), .rstN(rstN), .runTest(runTest), .opcode(opcode),
    .pinIn(pinIn), .seedLoad(seedLoad), .seedValue(seedValue),
    .shiftEn(shiftEn), .scanIn(scanIn), .pinOut(pinOut), .pinOe(pinOe),
    .coreIn(coreIn), .scanOut(scanOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference step, applied with the inputs present at the rising edge
  task automatic modelStep();
    logic [15:0] d;
    logic        f;
    if (seedLoad) begin
      mReg = seedValue; mIn = seedValue[7:0]; mOut = seedValue[15:8]; mOe = seedValue[16];
    end else if (shiftEn) begin
      mReg = {scanIn, mReg[17:1]};
    end else if (runTest) begin
      d = mReg[15:0];
      case (opcode)
        2'b00: begin
          d = {~d[15:8], pinIn};
          mReg[15:0] = d; mIn = d[7:0]; mOut = d[15:8];
        end
        2'b01: begin
          f = d[15] ^ d[11] ^ d[2] ^ d[0];
          d = {d[14:0], f};
          mReg[15:0] = d; mIn = d[7:0]; mOut = d[15:8];
        end
        2'b10: begin
          f = d[15] ^ d[11] ^ d[2] ^ d[0];
          d = {d[14:0], f} ^ {8'h00, pinIn};
          mReg[15:0] = d;
        end
        default: begin
          f = d[7] ^ d[3] ^ d[2] ^ d[1];
          d[7:0] = {d[6:0], f} ^ pinIn;
          f = d[15] ^ d[11] ^ d[10] ^ d[9];
          d[15:8] = {d[14:8], f};
          mReg[15:0] = d; mOut = d[15:8];
        end
      endcase
      mOe = mReg[16];
    end
  endtask

  // one clock: inputs already driven; returns after the falling edge
  task automatic tick();
    @(posedge tck);
    modelStep();
    #15;
  endtask

  task automatic chkPins(input string req);
    chk(req, {24'h0, pinOut}, {24'h0, mOut});
    chk(req, {24'h0, coreIn}, {24'h0, mIn});
    chk(req, {31'h0, pinOe}, {31'h0, mOe});
  endtask

  task automatic idleIn();
    seedLoad = 1'b0; shiftEn = 1'b0; runTest = 1'b0;
  endtask

  task automatic loadSeed(input logic [17:0] s);
    seedLoad = 1'b1; seedValue = s; tick(); idleIn();
  endtask

  // read all 18 cells serially, recirculating so contents are restored
  task automatic scanRead(input string req);
    for (int i = 0; i < 18; i++) begin
      chk(req, {31'h0, scanOut}, {31'h0, mReg[0]});
      shiftEn = 1'b1; scanIn = mReg[0];
      tick();
    end
    shiftEn = 1'b0;
  endtask

  initial begin
    #(150000 * 20);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge tck);
    #15;
    // R1: reset state
    chkPins("R1 reset");
    chk("R1 reset scanOut", {31'h0, scanOut}, 32'h0);
    rstN = 1'b1;
    tick();
    chkPins("R1 after release");

    // R2, R9: parallel load with drive enabled
    loadSeed(18'h1A53C);
    chkPins("R2/R9 load");
    // R3: shifting keeps pins and restores register
    scanRead("R3 scan after load");
    chkPins("R3 pins unchanged by shift");

    // R4: sample/toggle with varied pin data
    runTest = 1'b1; opcode = 2'b00;
    for (int i = 0; i < 12; i++) begin
      pinIn = 8'(i * 37 + 5);
      tick();
      chkPins("R4 sample/toggle");
    end
    idleIn();
    scanRead("R8 control cells after toggle");

    // R5, R9, R11: full pattern cycle, drive disabled, control bit 17 set
    loadSeed(18'h20001);
    runTest = 1'b1; opcode = 2'b01;
    for (int i = 0; i < 65535; i++) begin
      pinIn = 8'(i);
      tick();
      chk("R5 prpg pinOut", {24'h0, pinOut}, {24'h0, mOut});
      if (i % 4096 == 0) begin
        chk("R5 prpg coreIn", {24'h0, coreIn}, {24'h0, mIn});
        chk("R9 oe off", {31'h0, pinOe}, 32'h0);
      end
    end
    idleIn();
    chk("R11 period", {14'h0, mReg}, 32'h20001);
    scanRead("R11 back to seed");

    // R5: all-zero seed stays zero
    loadSeed(18'h10000);
    runTest = 1'b1; opcode = 2'b01;
    for (int i = 0; i < 20; i++) begin
      tick();
      chk("R5 zero seed pinOut", {24'h0, pinOut}, 32'h0);
      chk("R5 zero seed coreIn", {24'h0, coreIn}, 32'h0);
    end
    idleIn();

    // R6: 16-bit signature, data shadows hold
    loadSeed(18'h1F00F);
    runTest = 1'b1; opcode = 2'b10;
    for (int i = 0; i < 30; i++) begin
      pinIn = 8'(i * 91 + 17);
      tick();
      chk("R6 psa pinOut held", {24'h0, pinOut}, 32'hF0);
      chk("R6 psa coreIn held", {24'h0, coreIn}, 32'h0F);
    end
    idleIn();
    scanRead("R6 signature");

    // R10: freeze while idle with changing pins and opcodes
    for (int i = 0; i < 10; i++) begin
      pinIn = 8'(i * 29 + 3); opcode = 2'(i);
      tick();
      chkPins("R10 freeze");
    end
    scanRead("R10 register frozen");

    // R7: dual 8-bit mode
    loadSeed(18'h3817E);
    runTest = 1'b1; opcode = 2'b11;
    for (int i = 0; i < 40; i++) begin
      pinIn = 8'(i * 53 + 11);
      tick();
      chkPins("R7 dual");
    end
    idleIn();
    scanRead("R7 dual signature and R8 control");

    // R2: load beats shift and step; shift beats step
    seedLoad = 1'b1; shiftEn = 1'b1; runTest = 1'b1; opcode = 2'b01; seedValue = 18'h155AA;
    tick();
    idleIn();
    chkPins("R2 load priority");
    shiftEn = 1'b1; runTest = 1'b1; opcode = 2'b00; scanIn = 1'b1;
    tick();
    idleIn();
    chkPins("R2 shift over step");
    scanRead("R2 shift priority contents");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule